// File: doc/BRIEF.md
# Multichannel ADC Serial Frame Controller

The block is a host-side controller for an eight-channel, 12-bit successive-approximation converter with a four-wire serial port. It divides the system clock into a serial clock and runs conversion frames back to back, one after another, without a break. In each frame it drives chip select low, shifts the next channel address out on the data-in line, and samples the converted word from the data-out line. Each result appears on a valid/data/channel port.

Each frame has 16 serial clocks while chip select is low. During the first three of them, the converter tracks its input, and the controller sends the address of the channel to convert in the following frame. The converter returns four zero bits and then the 12-bit straight-binary result, most significant bit first. It changes its output on falling serial-clock edges, so the controller samples on rising edges. Because the address takes effect one frame late, every result is tagged with the address sent in the frame before. An idle gap of `GAP_SCLKS` serial periods follows each frame. At the defaults this gives 20 serial periods per frame. Channels come either from a fixed input or from a round-robin pointer.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While rst_ni is low (asynchronous), cs_no=1, sclk_o=1, din_o=0 and res_valid_o=0, and the round-robin pointer returns to channel 0.
- R2: cs_no stays low for exactly 16 sclk_o low pulses. sclk_o is high whenever cs_no is high. cs_no falls one half-period before the first sclk_o fall and rises one half-period after the last sclk_o rise. A new frame starts every 2*(16+GAP_SCLKS) half-periods.
- R3: Each sclk_o level lasts HALF_DIV system clocks, and so does the interval from the fall of cs_no to the first fall of sclk_o.
- R4: din_o carries the 3-bit channel address, most significant bit first, in serial cycles 0, 1 and 2 (cycle k starts at the k-th sclk_o fall). It is 0 in cycles 3 to 15 and changes only on a falling sclk_o edge.
- R5: dout_i is sampled at each rising sclk_o edge. The bits of cycles 0 to 3 are discarded whatever their value. The bits of cycles 4 to 15 form res_data_o, most significant bit first.
- R6: res_valid_o is high for exactly one system clock, the clock in which sclk_o has just risen in cycle 15 and cs_no is still low. There is one pulse per frame. res_data_o and res_ch_o hold until the next pulse.
- R7: res_ch_o equals the address sent on din_o in the frame before the one that produced the result.
- R8: No res_valid_o pulse is produced for the first frame after reset.
- R9: With mode_i=0, the address is fixed_ch_i as sampled on the clock in which cs_no falls. A change during a frame applies from the next frame.
- R10: With mode_i=1, the address is the round-robin pointer. The pointer steps by 1 modulo 8 after each round-robin frame, holds during fixed-mode frames and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Channel sequencing: 0 fixed, 1 round-robin |
| fixed_ch_i | input | 3 | Channel requested in fixed mode |
| dout_i | input | 1 | Serial result from the converter |
| sclk_o | output | 1 | Serial clock, idles high |
| cs_no | output | 1 | Chip select, active low |
| din_o | output | 1 | Serial address to the converter |
| res_valid_o | output | 1 | One-clock strobe for a new result |
| res_data_o | output | 12 | Converted word, straight binary |
| res_ch_o | output | 3 | Channel the result belongs to |

## Verification
The bench builds the controller with HALF_DIV=2 and GAP_SCLKS=4, so a frame takes only 80 system clocks. A run of a few dozen frames therefore covers several pointer wrap-arounds, mode switches between frames and a reset in mid-frame. The small divider also makes every timing interval short enough to count edge by edge. The default 12-bit result and 3-bit address keep the converter model's frame format identical to the controller's.

// File: rtl/adc_fc_pkg.sv
`timescale 1ns/1ps
package adc_fc_pkg;
  localparam int unsigned CH_W      = 3;
  localparam int unsigned RES_W     = 12;
  localparam int unsigned LEAD_BITS = 4;

  typedef enum logic {
    SEQ_FIXED = 1'b0,
    SEQ_ROUND = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/adc_fc_timer.sv
`timescale 1ns/1ps
// Half-period phase counter: one frame = 2*(FRAME_SCLKS+GAP_SCLKS) half-periods.
// Phase 0: CS falls; odd phases: SCLK falls; even phases 2..2F: SCLK rises.
module adc_fc_timer #(
  parameter int unsigned HALF_DIV    = 16,
  parameter int unsigned FRAME_SCLKS = 16,
  parameter int unsigned GAP_SCLKS   = 4,
  parameter int unsigned CW          = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          ev_start_o,
  output logic          ev_fall_o,
  output logic          ev_rise_o,
  output logic [CW-1:0] ev_cyc_o,
  output logic          sclk_o,
  output logic          cs_no
);
  localparam int unsigned TOT = 2 * (FRAME_SCLKS + GAP_SCLKS);
  localparam int unsigned HW  = $clog2(TOT);
  localparam int unsigned DW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] H_LAST      = HW'(TOT - 1);
  localparam logic [HW-1:0] H_LAST_FALL = HW'(2 * FRAME_SCLKS - 1);
  localparam logic [HW-1:0] H_LAST_RISE = HW'(2 * FRAME_SCLKS);
  localparam logic [DW-1:0] DIV_LAST    = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic [HW-1:0] h_q, h_nxt, h_m1;
  logic          tick, is_fall, is_rise, cs_act;

  assign tick    = (div_q == DIV_LAST);
  assign h_nxt   = (h_q == H_LAST) ? '0 : h_q + 1'b1;
  assign h_m1    = h_nxt - 1'b1;
  assign is_fall = h_nxt[0] && (h_nxt <= H_LAST_FALL);
  assign is_rise = !h_nxt[0] && (h_nxt != '0) && (h_nxt <= H_LAST_RISE);
  assign cs_act  = (h_nxt <= H_LAST_RISE);

  assign ev_start_o = tick && (h_nxt == '0);
  assign ev_fall_o  = tick && is_fall;
  assign ev_rise_o  = tick && is_rise;
  assign ev_cyc_o   = CW'(h_m1[HW-1:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      h_q    <= H_LAST;
      sclk_o <= 1'b1;
      cs_no  <= 1'b1;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        h_q    <= h_nxt;
        sclk_o <= !is_fall;
        cs_no  <= !cs_act;
      end
    end
  end
endmodule

// File: rtl/adc_fc_chsel.sv
`timescale 1ns/1ps
module adc_fc_chsel #(
  parameter int unsigned CH_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ev_start_i,
  input  adc_fc_pkg::seq_mode_e mode_i,
  input  logic [CH_W-1:0]       fixed_ch_i,
  output logic [CH_W-1:0]       req_ch_o,
  output logic [CH_W-1:0]       tag_ch_o,
  output logic                  tag_ok_o
);
  logic [CH_W-1:0] ptr_q;
  logic            started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      started_q <= 1'b0;
      req_ch_o  <= '0;
      tag_ch_o  <= '0;
      tag_ok_o  <= 1'b0;
    end else if (ev_start_i) begin
      // result of this frame belongs to the address sent last frame
      tag_ch_o  <= req_ch_o;
      tag_ok_o  <= started_q;
      started_q <= 1'b1;
      if (mode_i == adc_fc_pkg::SEQ_ROUND) begin
        req_ch_o <= ptr_q;
        ptr_q    <= ptr_q + 1'b1;
      end else begin
        req_ch_o <= fixed_ch_i;
      end
    end
  end
endmodule

// File: rtl/adc_fc_shift.sv
`timescale 1ns/1ps
module adc_fc_shift #(
  parameter int unsigned CH_W      = 3,
  parameter int unsigned RES_W     = 12,
  parameter int unsigned LEAD_BITS = 4,
  parameter int unsigned CW        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_fall_i,
  input  logic             ev_rise_i,
  input  logic [CW-1:0]    cyc_i,
  input  logic [CH_W-1:0]  req_ch_i,
  input  logic [CH_W-1:0]  tag_ch_i,
  input  logic             tag_ok_i,
  input  logic             dout_i,
  output logic             din_o,
  output logic             res_valid_o,
  output logic [RES_W-1:0] res_data_o,
  output logic [CH_W-1:0]  res_ch_o
);
  localparam int unsigned FRAME_SCLKS = LEAD_BITS + RES_W;
  localparam logic [CW-1:0] CYC_ADDR_END = CW'(CH_W);
  localparam logic [CW-1:0] CYC_DATA0    = CW'(LEAD_BITS);
  localparam logic [CW-1:0] CYC_LAST     = CW'(FRAME_SCLKS - 1);

  logic [CH_W-1:0]  tx_q;
  logic [RES_W-2:0] rx_q;

  // address out, changed on falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      din_o <= 1'b0;
    end else if (ev_fall_i) begin
      if (cyc_i == '0) begin
        din_o <= req_ch_i[CH_W-1];
        tx_q  <= req_ch_i << 1;
      end else if (cyc_i < CYC_ADDR_END) begin
        din_o <= tx_q[CH_W-1];
        tx_q  <= tx_q << 1;
      end else begin
        din_o <= 1'b0;
      end
    end
  end

  // result in, sampled on rising edges; leading bits skipped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q        <= '0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      res_ch_o    <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (ev_rise_i && (cyc_i >= CYC_DATA0)) begin
        rx_q <= {rx_q[RES_W-3:0], dout_i};
      end
      if (ev_rise_i && (cyc_i == CYC_LAST)) begin
        res_data_o  <= {rx_q, dout_i};
        res_ch_o    <= tag_ch_i;
        res_valid_o <= tag_ok_i;
      end
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
`timescale 1ns/1ps
module adc_frame_ctrl #(
  parameter int unsigned HALF_DIV  = 16,
  parameter int unsigned GAP_SCLKS = 4,
  parameter int unsigned CH_W      = adc_fc_pkg::CH_W,
  parameter int unsigned RES_W     = adc_fc_pkg::RES_W,
  parameter int unsigned LEAD_BITS = adc_fc_pkg::LEAD_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [CH_W-1:0]  fixed_ch_i,
  input  logic             dout_i,
  output logic             sclk_o,
  output logic             cs_no,
  output logic             din_o,
  output logic             res_valid_o,
  output logic [RES_W-1:0] res_data_o,
  output logic [CH_W-1:0]  res_ch_o
);
  localparam int unsigned FRAME_SCLKS = LEAD_BITS + RES_W;
  localparam int unsigned CW          = $clog2(FRAME_SCLKS);

  logic            ev_start, ev_fall, ev_rise, tag_ok;
  logic [CW-1:0]   ev_cyc;
  logic [CH_W-1:0] req_ch, tag_ch;

  adc_fc_timer #(
    .HALF_DIV   (HALF_DIV),
    .FRAME_SCLKS(FRAME_SCLKS),
    .GAP_SCLKS  (GAP_SCLKS),
    .CW         (CW)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_start_o(ev_start),
    .ev_fall_o (ev_fall),
    .ev_rise_o (ev_rise),
    .ev_cyc_o  (ev_cyc),
    .sclk_o    (sclk_o),
    .cs_no     (cs_no)
  );

  adc_fc_chsel #(
    .CH_W(CH_W)
  ) u_chsel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_start_i(ev_start),
    .mode_i    (adc_fc_pkg::seq_mode_e'(mode_i)),
    .fixed_ch_i(fixed_ch_i),
    .req_ch_o  (req_ch),
    .tag_ch_o  (tag_ch),
    .tag_ok_o  (tag_ok)
  );

  adc_fc_shift #(
    .CH_W     (CH_W),
    .RES_W    (RES_W),
    .LEAD_BITS(LEAD_BITS),
    .CW       (CW)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_fall_i  (ev_fall),
    .ev_rise_i  (ev_rise),
    .cyc_i      (ev_cyc),
    .req_ch_i   (req_ch),
    .tag_ch_i   (tag_ch),
    .tag_ok_i   (tag_ok),
    .dout_i     (dout_i),
    .din_o      (din_o),
    .res_valid_o(res_valid_o),
    .res_data_o (res_data_o),
    .res_ch_o   (res_ch_o)
  );
endmodule

// File: rtl/adc_fc_chk.sv
`timescale 1ns/1ps
module adc_fc_chk #(
  parameter int unsigned HALF_DIV = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic din_o,
  input logic res_valid_o
);
  logic        sclk_q, cs_q;
  int unsigned run_cnt;

  // clocks since the last change of sclk_o or cs_no
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b1;
      cs_q    <= 1'b1;
      run_cnt <= 0;
    end else begin
      sclk_q  <= sclk_o;
      cs_q    <= cs_no;
      run_cnt <= ((sclk_o != sclk_q) || (cs_no != cs_q)) ? 0 : run_cnt + 1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (cs_no && sclk_o && !din_o && !res_valid_o));

  assert_sclk_high_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  assert_half_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sclk_o != sclk_q) && !cs_no) |-> (run_cnt == HALF_DIV - 1));

  assert_din_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(din_o) |-> $fell(sclk_o));

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_valid_at_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ($rose(sclk_o) && !cs_no));
endmodule

bind adc_frame_ctrl adc_fc_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_no      (cs_no),
  .sclk_o     (sclk_o),
  .din_o      (din_o),
  .res_valid_o(res_valid_o)
);

// File: tb/adc_frame_ctrl_test.sv
`timescale 1ns/1ps
module adc_frame_ctrl_test;
  localparam int HALF_DIV = 2;
  localparam int GAP      = 4;
  localparam int FRAME    = 16;
  localparam int HALF_CLK = HALF_DIV;
  localparam int CSLO_CLK = (2 * FRAME + 1) * HALF_DIV;
  localparam int PER_CLK  = 2 * (FRAME + GAP) * HALF_DIV;

  // {mode, fixed channel, frames to run}
  localparam logic [7:0] VEC [8] = '{
    {1'b0, 3'd5, 4'd3}, {1'b1, 3'd0, 4'd10}, {1'b0, 3'd7, 4'd2},
    {1'b1, 3'd0, 4'd4}, {1'b0, 3'd0, 4'd2},  {1'b0, 3'd3, 4'd2},
    {1'b1, 3'd6, 4'd3}, {1'b0, 3'd1, 4'd2}
  };

  logic        clk, rst_ni, mode, dout;
  logic [2:0]  fixed_ch;
  logic        sclk, cs_n, din, res_valid;
  logic [11:0] res_data;
  logic [2:0]  res_ch;

  int n_run = 0, n_fail = 0;
  int cyc_cnt = 0;

  // converter model state
  logic [11:0] chan_val [8];
  logic [15:0] word;
  logic [2:0]  conv_ch, exp_req, addr_cap;
  bit          lead_ones = 0, aborted = 1, in_frame = 0, frame_rr = 0, din_bad = 0;
  int          frame_idx = 0, falls = 0, bitpos = 0, rr_ptr = 0;
  logic [11:0] q_data [8];
  logic [2:0]  q_ch [8];
  int          q_wr = 0, q_rd = 0, n_valid = 0;
  bit          prev_v = 0;

  adc_frame_ctrl #(.HALF_DIV(HALF_DIV), .GAP_SCLKS(GAP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .fixed_ch_i(fixed_ch), .dout_i(dout),
    .sclk_o(sclk), .cs_no(cs_n), .din_o(din), .res_valid_o(res_valid),
    .res_data_o(res_data), .res_ch_o(res_ch)
  );

  initial begin
    clk = 0;
    forever #2 clk = ~clk;
  end

  initial forever @(posedge clk) cyc_cnt++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    aborted = 1;
    rst_ni  = 0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1, "R1", "cs_no in reset", int'(cs_n), 1);
    chk(sclk === 1'b1, "R1", "sclk_o in reset", int'(sclk), 1);
    chk(din === 1'b0 && res_valid === 1'b0, "R1", "din_o/res_valid_o in reset",
        int'({din, res_valid}), 0);
    conv_ch = 0; frame_idx = 0; rr_ptr = 0; q_wr = 0; q_rd = 0; prev_v = 0;
    @(negedge clk);
    rst_ni = 1;
  endtask

  // converter model: result out on falling edges, address captured on rising edges
  initial begin
    dout = 0;
    forever begin
      @(cs_n or negedge sclk);
      if (cs_n === 1'b1) begin
        if (in_frame && !aborted) begin
          chk(falls == FRAME, "R2", "sclk falls per frame", falls, FRAME);
          chk(addr_cap == exp_req, frame_rr ? "R10" : "R9", "requested address",
              int'(addr_cap), int'(exp_req));
          chk(!din_bad, "R4", "din_o zero after address", int'(din_bad), 0);
          conv_ch = addr_cap;
        end
        in_frame = 0;
      end else if (sclk === 1'b0) begin
        if (in_frame) begin
          dout = word[15-bitpos];
          bitpos++;
          falls++;
        end
      end else begin
        aborted = 0; in_frame = 1; falls = 0; bitpos = 0; din_bad = 0; addr_cap = 0;
        if (frame_idx >= 2) chk(q_rd == q_wr, "R6", "result of previous frame delivered", q_rd, q_wr);
        word = {lead_ones ? 4'hF : 4'h0, chan_val[conv_ch]};
        if (frame_idx > 0) begin
          q_data[q_wr % 8] = chan_val[conv_ch];
          q_ch[q_wr % 8]   = conv_ch;
          q_wr++;
        end
        frame_idx++;
        frame_rr = mode;
        if (mode) begin
          exp_req = rr_ptr[2:0];
          rr_ptr  = (rr_ptr + 1) % 8;
        end else begin
          exp_req = fixed_ch;
        end
      end
    end
  end

  initial forever begin
    @(posedge sclk);
    if (in_frame && !aborted && cs_n === 1'b0) begin
      if (falls <= 3) addr_cap = {addr_cap[1:0], din};
      else if (din !== 1'b0) din_bad = 1;
    end
  end

  // result monitor
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      if (res_valid) begin
        n_valid++;
        chk(!prev_v && sclk === 1'b1 && cs_n === 1'b0, "R6", "valid timing",
            int'({prev_v, sclk, cs_n}), 3'b010);
        if (q_rd == q_wr) begin
          chk(0, "R8", "valid with no pending frame", 1, 0);
        end else begin
          chk(res_data == q_data[q_rd % 8], "R5", "result data", int'(res_data), int'(q_data[q_rd % 8]));
          chk(res_ch == q_ch[q_rd % 8], "R7", "result channel tag", int'(res_ch), int'(q_ch[q_rd % 8]));
          q_rd++;
        end
      end
      prev_v = res_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, nv0;
    for (int c = 0; c < 8; c++) chan_val[c] = 12'(12'h15B + c * 12'h2D1);
    mode = 0; fixed_ch = 0;
    rst_ni = 1;
    #1;
    do_reset();  // R1

    // table walk: R9, R10, R7, R5
    for (int i = 0; i < 8; i++) begin
      @(negedge cs_n);
      #1;
      mode     = VEC[i][7];
      fixed_ch = VEC[i][6:4];
      repeat (int'(VEC[i][3:0])) @(negedge cs_n);
    end

    // frame and half-period timing: R2, R3
    @(negedge cs_n); t0 = cyc_cnt;
    @(negedge sclk); t1 = cyc_cnt;
    @(posedge sclk); t2 = cyc_cnt;
    chk(t1 - t0 == HALF_CLK, "R3", "cs fall to first sclk fall", t1 - t0, HALF_CLK);
    chk(t2 - t1 == HALF_CLK, "R3", "sclk low time", t2 - t1, HALF_CLK);
    @(posedge cs_n); t3 = cyc_cnt;
    chk(t3 - t0 == CSLO_CLK, "R2", "cs low duration", t3 - t0, CSLO_CLK);
    @(negedge cs_n);
    chk(cyc_cnt - t0 == PER_CLK, "R2", "frame period", cyc_cnt - t0, PER_CLK);

    // full-scale and zero-scale words: R5
    #1;
    for (int c = 0; c < 8; c++) chan_val[c] = 12'hFFF;
    repeat (3) @(negedge cs_n);
    #1;
    for (int c = 0; c < 8; c++) chan_val[c] = 12'h000;
    repeat (3) @(negedge cs_n);

    // leading bits driven high must not reach the result: R5
    #1;
    for (int c = 0; c < 8; c++) chan_val[c] = 12'(12'h9A6 ^ (c * 12'h135));
    lead_ones = 1;
    mode = 1;
    repeat (4) @(negedge cs_n);
    #1;
    lead_ones = 0;

    // reset in mid-frame: R1, R8, pointer back to 0 checked as R10
    @(negedge cs_n);
    repeat (10) @(negedge clk);
    do_reset();
    nv0 = n_valid;
    @(negedge cs_n);
    @(negedge cs_n);
    chk(n_valid == nv0, "R8", "no valid for first frame after reset", n_valid, nv0);
    @(posedge cs_n);
    @(negedge clk);
    chk(n_valid == nv0 + 1, "R8", "valid resumes in second frame", n_valid, nv0 + 1);
    repeat (2) @(negedge cs_n);
    chk(n_valid > 30, "R6", "results delivered overall", n_valid, 31);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule